// File: doc/BRIEF.md
# Cascadable Loadable Up/Down Counter

This block is a synchronous binary counter built from 4-bit slices. The default build joins two slices into an 8-bit counter. On each rising clock edge the counter loads a parallel value, counts up, counts down, or holds. An active-low enable and an active-low load strobe select the action, and a direction input chooses between counting up and counting down. An asynchronous clear returns every bit to zero at once, without waiting for a clock edge.

Each slice raises an active-low terminal flag when its count is at the end of the current direction: all ones when counting up, all zeros when counting down. The flag of the lower slice is the count enable of the slice above it. An upper slice therefore advances on exactly one edge each time the slices below it sit at their terminal value. A parallel load, when enabled, writes every slice in the same edge. The terminal flag of the whole counter comes out on `co_n`, so a wider chain can be built from several of these counters.

Top module: `ctr_cascade`

## Requirements
- R1: While `clr` is 1, `q` is zero at once, without a clock edge, and stays zero at every edge, whatever `en_n`, `ld_n`, `up` and `d` hold.
- R2: On a rising edge with `en_n`=0, `ld_n`=1 and `up`=1, `q` becomes its previous value plus one, and all ones wraps to zero.
- R3: On a rising edge with `en_n`=0, `ld_n`=1 and `up`=0, `q` becomes its previous value minus one, and zero wraps to all ones.
- R4: On a rising edge with `en_n`=0 and `ld_n`=0, `q` takes the value of `d` in every slice, whatever `up` holds. Loading takes priority over counting.
- R5: On a rising edge with `en_n`=1, `q` keeps its value. A pending load has no effect, and an upper slice does not move even when the slices below it are at their terminal value.
- R6: `co_n` is 0 exactly when `q` is all ones with `up`=1, or when `q` is zero with `up`=0. Otherwise it is 1. It follows `q` and `up` with no register in between.
- R7: An upper 4-bit slice changes during counting only on edges where every slice below it is at its terminal value. On other edges only the lower slices move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| ld_n | input | 1 | Parallel load request, active low |
| en_n | input | 1 | Enable for counting and loading, active low |
| d | input | SLICE_W*SLICES | Parallel load value |
| q | output | SLICE_W*SLICES | Current count |
| co_n | output | 1 | Terminal-count flag, active low |

## Verification
The bench provokes the collisions between functions that can happen in one cycle. It requests a load and a count in the same edge and expects the loaded value rather than an incremented one. It holds a load request while the enable is off and expects the count to stay put. It also holds the clear while both the load and the enable are active, and expects the count to stay zero. It then places the lower nibble at its terminal value while the counter is disabled, to confirm that the cascade carry alone cannot move the upper nibble.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_INC  = 2'd2,
      OP_DEC  = 2'd3
   } op_e;

   // Priority: disabled -> hold; load beats counting.
   function automatic op_e pick_op(input logic en_n, input logic ld_n, input logic up);
      if (en_n)      return OP_HOLD;
      else if (!ld_n) return OP_LOAD;
      else if (up)    return OP_INC;
      else            return OP_DEC;
   endfunction

endpackage

// File: rtl/nib_ctrl.sv
module nib_ctrl
   import cnt_pkg::*;
(
   input  logic en_n,
   input  logic ld_n,
   input  logic up,
   output op_e  op
);
   always_comb op = pick_op(en_n, ld_n, up);
endmodule

// File: rtl/nib_term.sv
module nib_term #(
   parameter int W = 4
) (
   input  logic [W-1:0] q,
   input  logic         up,
   output logic         term_n
);
   logic at_top, at_bot;
   always_comb begin
      at_top = &q;
      at_bot = ~|q;
      term_n = ~((at_top & up) | (at_bot & ~up));
   end
endmodule

// File: rtl/nib_slice.sv
module nib_slice
   import cnt_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         up,
   input  logic         ld_n,
   input  logic         en_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         term_n
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   op_e          op;
   logic [W-1:0] q_r;
   logic [W-1:0] nxt;

   nib_ctrl u_ctrl (
      .en_n (en_n),
      .ld_n (ld_n),
      .up   (up),
      .op   (op)
   );

   always_comb begin
      unique case (op)
         OP_LOAD: nxt = d;
         OP_INC:  nxt = q_r + ONE;
         OP_DEC:  nxt = q_r - ONE;
         default: nxt = q_r;
      endcase
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr) q_r <= '0;
      else     q_r <= nxt;
   end

   nib_term #(.W(W)) u_term (
      .q      (q_r),
      .up     (up),
      .term_n (term_n)
   );

   assign q = q_r;
endmodule

// File: rtl/ctr_cascade.sv
module ctr_cascade #(
   parameter int SLICE_W = 4,
   parameter int SLICES  = 2
) (
   input  logic                      clk,
   input  logic                      clr,
   input  logic                      up,
   input  logic                      ld_n,
   input  logic                      en_n,
   input  logic [SLICE_W*SLICES-1:0] d,
   output logic [SLICE_W*SLICES-1:0] q,
   output logic                      co_n
);
   localparam int TOTAL_W = SLICE_W * SLICES;

   if (SLICE_W != 4) begin : g_bad_w
      $error("ctr_cascade: SLICE_W must be 4");
   end
   if (SLICES < 1 || SLICES > 16) begin : g_bad_n
      $error("ctr_cascade: SLICES must be 1..16");
   end

   // chain_n[k] is low when every slice below k is at its terminal value
   logic [SLICES:0]   chain_n;
   logic [SLICES-1:0] term_n;
   logic [SLICES-1:0] sen_n;

   assign chain_n[0] = 1'b0;

   for (genvar k = 0; k < SLICES; k++) begin : g_slice
      assign chain_n[k+1] = chain_n[k] | term_n[k];

      if (k == 0) begin : g_low
         assign sen_n[k] = en_n;
      end else begin : g_high
         // loads reach every slice; counts need the carry from below
         assign sen_n[k] = en_n | (ld_n & chain_n[k]);
      end

      nib_slice #(.W(SLICE_W)) u_nib (
         .clk    (clk),
         .clr    (clr),
         .up     (up),
         .ld_n   (ld_n),
         .en_n   (sen_n[k]),
         .d      (d[k*SLICE_W +: SLICE_W]),
         .q      (q[k*SLICE_W +: SLICE_W]),
         .term_n (term_n[k])
      );
   end

   assign co_n = chain_n[SLICES];

   logic unused_w;
   assign unused_w = ^TOTAL_W;
endmodule

// File: rtl/ctr_cascade_chk.sv
module ctr_cascade_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         clr,
   input logic         up,
   input logic         ld_n,
   input logic         en_n,
   input logic [W-1:0] d,
   input logic [W-1:0] q,
   input logic         co_n
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   // R1
   always @(negedge clk) begin
      if (clr === 1'b1) begin
         clear_zero_chk: assert (q == '0);
      end
   end

   // R2
   count_up_chk: assert property (@(posedge clk) disable iff (clr)
      (!en_n && ld_n && up) |=> (q == $past(q) + ONE));

   // R3
   count_down_chk: assert property (@(posedge clk) disable iff (clr)
      (!en_n && ld_n && !up) |=> (q == $past(q) - ONE));

   // R4
   load_chk: assert property (@(posedge clk) disable iff (clr)
      (!en_n && !ld_n) |=> (q == $past(d)));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (clr)
      en_n |=> $stable(q));

   // R6
   term_up_chk: assert property (@(posedge clk) disable iff (clr)
      (up && (&q)) |-> !co_n);

   // R6
   term_down_chk: assert property (@(posedge clk) disable iff (clr)
      (!up && (q == '0)) |-> !co_n);

   // R6
   term_only_chk: assert property (@(posedge clk) disable iff (clr)
      !co_n |-> ((up && (&q)) || (!up && (q == '0))));

   // R7
   upper_still_chk: assert property (@(posedge clk) disable iff (clr)
      (!en_n && ld_n && up && !(&q[3:0])) |=> (q[W-1:4] == $past(q[W-1:4])));
endmodule

bind ctr_cascade ctr_cascade_chk #(.W(SLICE_W*SLICES)) u_chk (
   .clk  (clk),
   .clr  (clr),
   .up   (up),
   .ld_n (ld_n),
   .en_n (en_n),
   .d    (d),
   .q    (q),
   .co_n (co_n)
);

// File: tb/tb_ctr_cascade.sv
module tb_ctr_cascade;
   logic       clk = 1'b0;
   logic       clr, up, ld_n, en_n;
   logic [7:0] d;
   logic [7:0] q;
   logic       co_n;
   int         n_chk = 0;
   int         n_bad = 0;

   always #5 clk = ~clk;

   ctr_cascade dut (
      .clk(clk), .clr(clr), .up(up), .ld_n(ld_n), .en_n(en_n),
      .d(d), .q(q), .co_n(co_n)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // advance past one rising edge; sample 2 ns after it
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic preload(input logic [7:0] v);
      en_n = 1'b0; ld_n = 1'b0; d = v;
      tick();
      ld_n = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 reset q", q, 8'h00);
      chk("R6 reset co_n up", {7'd0, co_n}, 8'd1);
   endtask

   task automatic t_clear();
      preload(8'h5A);
      chk("R4 load 5A", q, 8'h5A);
      en_n = 1'b1;
      #1 clr = 1'b1;
      #1 chk("R1 async clear", q, 8'h00);
      en_n = 1'b0; ld_n = 1'b0; d = 8'h77;
      tick();
      chk("R1 clear beats load", q, 8'h00);
      clr = 1'b0; ld_n = 1'b1; en_n = 1'b1;
      tick();
   endtask

   task automatic t_up();
      preload(8'h1E);
      up = 1'b1;
      tick();
      chk("R7 1E->1F upper still", q, 8'h1F);
      tick();
      chk("R2 1F->20 carry", q, 8'h20);
      preload(8'hFE);
      up = 1'b1;
      tick();
      chk("R2 FE->FF", q, 8'hFF);
      chk("R6 FF up co_n", {7'd0, co_n}, 8'd0);
      en_n = 1'b1;
      up = 1'b0;
      #1 chk("R6 FF down co_n", {7'd0, co_n}, 8'd1);
      up = 1'b1; en_n = 1'b0;
      tick();
      chk("R2 wrap FF->00", q, 8'h00);
   endtask

   task automatic t_down();
      preload(8'h21);
      up = 1'b0;
      tick();
      chk("R3 21->20", q, 8'h20);
      tick();
      chk("R3 20->1F borrow", q, 8'h1F);
      tick();
      chk("R7 1F->1E upper still", q, 8'h1E);
      preload(8'h00);
      up = 1'b0;
      #1 chk("R6 00 down co_n", {7'd0, co_n}, 8'd0);
      tick();
      chk("R3 wrap 00->FF", q, 8'hFF);
   endtask

   task automatic t_collide();
      preload(8'h42);
      up = 1'b1; ld_n = 1'b0; d = 8'h9C;
      tick();
      chk("R4 load beats count", q, 8'h9C);
      en_n = 1'b1; d = 8'h13;
      tick();
      chk("R5 load ignored when disabled", q, 8'h9C);
      ld_n = 1'b1;
      preload(8'h3F);
      en_n = 1'b1; up = 1'b1;
      tick();
      chk("R5 lower terminal no upper move", q, 8'h3F);
      tick();
      chk("R5 still held", q, 8'h3F);
   endtask

   initial begin
      clr = 1'b1; up = 1'b1; ld_n = 1'b1; en_n = 1'b1; d = 8'h00;
      #13 clr = 1'b0;
      t_reset();
      t_clear();
      t_up();
      t_down();
      t_collide();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule